// File: doc/BRIEF.md
# Serial Register Write Port

This block is the write side of a three-wire register port: a serial clock, an active-low load strobe and a data line. A host shifts in frames of 40 bits while the strobe is low. Each frame carries a 12-bit register address followed by a 28-bit data word, and both fields travel least significant bit first. The three serial pins are brought into the system clock domain through a synchronizer chain. Rising serial-clock edges are detected in that domain.

The 40th bit of a frame commits the write. Each register slot has a fixed update class. An immediate slot takes the new value at once. A frame-class slot holds it in a shadow copy until the next frame strobe. A region-class slot holds it in a shadow copy until the next region-change strobe. A frame that ends early is thrown away, and bits after the 40th are ignored. Several writes to a deferred slot before its strobe leave only the last value to be applied. The outputs are the active values of all slots, packed side by side.

Top module: `sreg_loader`

## Requirements
- R1: After reset every active register reads zero and no deferred write is pending.
- R2: The first bit of a frame is address bit 0 and the 13th bit is data bit 0. Address occupies frame bits 0 to 11 and data occupies frame bits 12 to 39.
- R3: A bit is taken only on a rising `ser_clk` edge while `ser_load_n` is low. Raising `ser_load_n` clears the bit count, and serial clock edges while it is high change nothing.
- R4: The write is committed when the 40th bit is taken. Further bits in the same strobe are ignored.
- R5: If `ser_load_n` rises before 40 bits have been taken, the frame is discarded and no register changes.
- R6: The class of slot i is the field `CLASS_MAP[2i+1:2i]`: 0 is immediate, 1 is frame-strobe, 2 is region-strobe. With the default map, slot i has class i mod 3. An immediate slot shows the new value SYNC_STAGES+1 clock cycles after the serial edge of the 40th bit has been sampled.
- R7: A frame-class slot keeps its active value until a clock cycle in which `vd_strobe` is high. In that cycle the active value takes the newest shadowed write, provided a write arrived since the last application.
- R8: A region-class slot is updated only by `scp_strobe`, in the same way as R7. `vd_strobe` leaves region-class slots unchanged, and `scp_strobe` leaves frame-class slots unchanged.
- R9: If a deferred slot is written several times before its strobe, the strobe applies only the last value. A later strobe with no new write leaves the slot unchanged.
- R10: A frame whose full 12-bit address lies outside BASE_ADDR to BASE_ADDR+NUM_REGS-1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic and the strobes are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_load_n | input | 1 | Active-low frame strobe |
| ser_data | input | 1 | Serial data, address first, LSB first |
| vd_strobe | input | 1 | One-cycle frame strobe that applies frame-class writes |
| scp_strobe | input | 1 | One-cycle region-change strobe that applies region-class writes |
| act_regs | output | NUM_REGS*DATA_W | Active register values; slot i at bits i*DATA_W and up |

## Verification
Some properties are checked on every cycle:
- the bit counter never passes 40 and clears while the strobe is high;
- a commit happens only on the 40th bit with the strobe low;
- every slot holds its value except on its own update event (a commit for immediate slots, the matching strobe for deferred ones);
- an out-of-range commit changes nothing.

Other behaviour can only be shown by the bench scenarios:
- which register a frame reaches and the bit order of its fields;
- that a short frame leaves no trace;
- that bits past the 40th are ignored;
- that the last of several deferred writes wins;
- that a repeated strobe does not re-apply a value.

A cycle-level reference model also fixes the exact cycle in which each active value changes.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   // update timing class of one register slot
   typedef enum logic [1:0] {
      UPD_NOW = 2'd0,
      UPD_VD  = 2'd1,
      UPD_SCP = 2'd2
   } upd_class_e;

   // the three serial pins as one bundle
   typedef struct packed {
      logic sck;
      logic load_n;
      logic sdat;
   } ser_pins_t;

   localparam ser_pins_t PINS_IDLE = '{sck: 1'b0, load_n: 1'b1, sdat: 1'b0};

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST   = '0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(STAGES); i++) st[i] <= RST;
            end else begin
               st[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sreg_deframe.sv
module sreg_deframe #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 28,
   localparam int unsigned FRAME_W = ADDR_W + DATA_W,
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              load_n,
   input  logic              sdat,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  bit_cnt
);

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic               sck_d;
   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] frame;
   logic               take;

   // new bit enters at the top, so the first bit ends up at position 0
   assign frame   = {sdat, shreg[FRAME_W-1:1]};
   assign take    = sck && !sck_d && !load_n && (bit_cnt < CNT_FULL);
   assign wr_en   = take && (bit_cnt == CNT_LAST);
   assign wr_addr = frame[ADDR_W-1:0];
   assign wr_data = frame[FRAME_W-1:ADDR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d   <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
      end else begin
         sck_d <= sck;
         if (load_n)
            bit_cnt <= '0;
         else if (take)
            bit_cnt <= bit_cnt + 1'b1;
         if (take)
            shreg <= frame;
      end
   end

endmodule

// File: rtl/sreg_slot.sv
module sreg_slot
   import sreg_pkg::*;
#(
   parameter int unsigned DATA_W = 28,
   parameter upd_class_e  CLASS  = UPD_NOW
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              apply,
   output logic [DATA_W-1:0] act
);

   generate
      if (CLASS == UPD_NOW) begin : g_now
         logic unused_apply;
         assign unused_apply = apply;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   act <= '0;
            else if (hit) act <= wr_data;
         end
      end else if (CLASS == UPD_VD || CLASS == UPD_SCP) begin : g_defer
         logic [DATA_W-1:0] shadow;
         logic              pend;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow <= '0;
               pend   <= 1'b0;
               act    <= '0;
            end else begin
               if (hit)           shadow <= wr_data;
               if (apply && pend) act    <= shadow;
               pend <= hit || (pend && !apply);
            end
         end
      end else begin : g_bad_class
         $error("sreg_slot: unsupported update class");
      end
   endgenerate

endmodule

// File: rtl/sreg_loader.sv
module sreg_loader
   import sreg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 28,
   parameter int unsigned NUM_REGS    = 8,
   parameter int unsigned BASE_ADDR   = 0,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [2*NUM_REGS-1:0] CLASS_MAP = 16'h4924
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ser_clk,
   input  logic                       ser_load_n,
   input  logic                       ser_data,
   input  logic                       vd_strobe,
   input  logic                       scp_strobe,
   output logic [NUM_REGS*DATA_W-1:0] act_regs
);

   localparam int unsigned FRAME_W = ADDR_W + DATA_W;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (NUM_REGS == 0 || ADDR_W == 0 || DATA_W == 0) begin : g_bad_size
         $error("sreg_loader: sizes must be non-zero");
      end
      if (BASE_ADDR + NUM_REGS > (64'd1 << ADDR_W)) begin : g_bad_range
         $error("sreg_loader: register window exceeds address space");
      end
   endgenerate

   ser_pins_t pins_raw, pins_s;
   logic      load_s;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [CNT_W-1:0]  frm_cnt;

   assign pins_raw = '{sck: ser_clk, load_n: ser_load_n, sdat: ser_data};
   assign load_s   = pins_s.load_n;

   sreg_sync #(
      .W      ($bits(ser_pins_t)),
      .STAGES (SYNC_STAGES),
      .RST    (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   sreg_deframe #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_deframe (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck     (pins_s.sck),
      .load_n  (load_s),
      .sdat    (pins_s.sdat),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .bit_cnt (frm_cnt)
   );

   generate
      for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_slot
         localparam upd_class_e CLS = upd_class_e'(CLASS_MAP[2*g +: 2]);
         logic hit;
         logic apply;
         assign hit   = wr_en && (wr_addr == ADDR_W'(BASE_ADDR + g));
         assign apply = (CLS == UPD_VD) ? vd_strobe : scp_strobe;

         sreg_slot #(
            .DATA_W (DATA_W),
            .CLASS  (CLS)
         ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit),
            .wr_data (wr_data),
            .apply   (apply),
            .act     (act_regs[g*DATA_W +: DATA_W])
         );
      end
   endgenerate

endmodule

// File: rtl/sreg_chk.sv
module sreg_chk #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 28,
   parameter int unsigned NUM_REGS  = 8,
   parameter int unsigned BASE_ADDR = 0,
   parameter logic [2*NUM_REGS-1:0] CLASS_MAP = 16'h4924,
   localparam int unsigned FRAME_W  = ADDR_W + DATA_W,
   localparam int unsigned CNT_W    = $clog2(FRAME_W + 1)
)(
   input logic                       clk,
   input logic                       rst_n,
   input logic                       vd_strobe,
   input logic                       scp_strobe,
   input logic [NUM_REGS*DATA_W-1:0] act_regs,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [CNT_W-1:0]           frm_cnt,
   input logic                       load_s
);

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic out_of_range;
   assign out_of_range = (32'(wr_addr) < BASE_ADDR) ||
                         (32'(wr_addr) >= BASE_ADDR + NUM_REGS);

   // R4: the counter saturates at a full frame
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frm_cnt <= CNT_FULL);

   // R3: an inactive strobe clears the count
   p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_s |=> (frm_cnt == '0));

   // R5: a commit only on the last bit of a frame with the strobe active
   p_commit_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!load_s && frm_cnt == CNT_LAST));

   // R10: an out-of-window commit changes no slot
   p_oor_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && out_of_range && !vd_strobe && !scp_strobe) |=> $stable(act_regs));

   generate
      for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_slot_chk
         if (CLASS_MAP[2*g +: 2] == 2'd0) begin : g_now
            // R6: an immediate slot changes only after a commit
            p_imm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
               !wr_en |=> $stable(act_regs[g*DATA_W +: DATA_W]));
         end else if (CLASS_MAP[2*g +: 2] == 2'd1) begin : g_vd
            // R7: a frame-class slot changes only on the frame strobe
            p_vd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
               !vd_strobe |=> $stable(act_regs[g*DATA_W +: DATA_W]));
         end else begin : g_scp
            // R8: a region-class slot changes only on the region strobe
            p_scp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
               !scp_strobe |=> $stable(act_regs[g*DATA_W +: DATA_W]));
         end
      end
   endgenerate

endmodule

bind sreg_loader sreg_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .NUM_REGS  (NUM_REGS),
   .BASE_ADDR (BASE_ADDR),
   .CLASS_MAP (CLASS_MAP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vd_strobe  (vd_strobe),
   .scp_strobe (scp_strobe),
   .act_regs   (act_regs),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .frm_cnt    (frm_cnt),
   .load_s     (load_s)
);

// File: tb/sim_sreg_loader.sv
module sim_sreg_loader;

   localparam int NR   = 8;
   localparam int DW   = 28;
   localparam int AW   = 12;
   localparam int FW   = AW + DW;
   localparam int SYNC = 2;
   localparam int HOLD = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_load_n = 1'b1;
   logic ser_data = 1'b0;
   logic vd_strobe = 1'b0;
   logic scp_strobe = 1'b0;
   logic [NR*DW-1:0] act_regs;

   always #5 clk = ~clk;

   sreg_loader #(
      .ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR), .BASE_ADDR(0),
      .SYNC_STAGES(SYNC), .CLASS_MAP(16'h4924)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_load_n(ser_load_n),
      .ser_data(ser_data), .vd_strobe(vd_strobe), .scp_strobe(scp_strobe),
      .act_regs(act_regs)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp,
                      input string tag, input string what);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic logic [DW-1:0] reg_of(int i);
      return act_regs[i*DW +: DW];
   endfunction

   // ---------------- behavioural reference model ----------------
   logic [2:0]    pin_q[$];
   logic [2:0]    m_d;
   int            m_cnt;
   bit            m_prev;
   bit            m_wr;
   int            m_a;
   logic [FW-1:0] m_frame;
   logic [DW-1:0] m_act [NR];
   logic [DW-1:0] m_shd [NR];
   bit            m_pend [NR];

   always @(posedge clk) begin
      if (!rst_n) begin
         pin_q.delete();
         for (int i = 0; i < SYNC; i++) pin_q.push_back(3'b010);
         m_cnt = 0;
         m_prev = 1'b0;
         m_frame = '0;
         for (int i = 0; i < NR; i++) begin
            m_act[i] = '0; m_shd[i] = '0; m_pend[i] = 1'b0;
         end
      end else begin
         pin_q.push_back({ser_clk, ser_load_n, ser_data});
         m_d = pin_q.pop_front();
         m_wr = 1'b0;
         if (m_d[1]) m_cnt = 0;
         else if (m_d[2] && !m_prev && m_cnt < FW) begin
            m_frame[m_cnt] = m_d[0];
            m_cnt++;
            if (m_cnt == FW) m_wr = 1'b1;
         end
         m_prev = m_d[2];
         for (int i = 0; i < NR; i++) begin
            if (((i % 3 == 1 && vd_strobe) || (i % 3 == 2 && scp_strobe)) && m_pend[i]) begin
               m_act[i] = m_shd[i];
               m_pend[i] = 1'b0;
            end
         end
         if (m_wr) begin
            m_a = int'(m_frame[AW-1:0]);
            if (m_a < NR) begin
               if (m_a % 3 == 0) m_act[m_a] = m_frame[FW-1:AW];
               else begin
                  m_shd[m_a] = m_frame[FW-1:AW];
                  m_pend[m_a] = 1'b1;
               end
            end
         end
      end
   end

   // R6: per-cycle comparison fixes the update cycle of every slot
   always @(negedge clk) begin
      if (rst_n && !done)
         for (int i = 0; i < NR; i++) chk(reg_of(i), m_act[i], "R6", "per-cycle model");
   end

   // ---------------- stimulus ----------------
   task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input int nbits);
      logic [FW-1:0] f;
      f = {d, a};
      @(negedge clk) ser_load_n = 1'b0;
      repeat (HOLD) @(negedge clk);
      for (int b = 0; b < nbits; b++) begin
         ser_data = (b < FW) ? f[b] : b[0];
         repeat (HOLD) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HOLD) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (HOLD) @(negedge clk);
      ser_load_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic pulse_vd();
      @(negedge clk) vd_strobe = 1'b1;
      @(negedge clk) vd_strobe = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse_scp();
      @(negedge clk) scp_strobe = 1'b1;
      @(negedge clk) scp_strobe = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NR; i++) chk(reg_of(i), '0, "R1", "reset value");

      send(12'd0, 28'hABCDEF1, 40);
      chk(reg_of(0), 28'hABCDEF1, "R2", "immediate slot 0");
      send(12'd3, 28'h0000001, 40);
      chk(reg_of(3), 28'h0000001, "R2", "data LSB position");

      send(12'd1, 28'h1234567, 40);
      chk(reg_of(1), '0, "R7", "frame-class held before strobe");
      pulse_scp();
      chk(reg_of(1), '0, "R8", "region strobe leaves frame-class slot");
      pulse_vd();
      chk(reg_of(1), 28'h1234567, "R7", "frame-class applied on strobe");

      send(12'd2, 28'h7654321, 40);
      pulse_vd();
      chk(reg_of(2), '0, "R8", "frame strobe leaves region-class slot");
      pulse_scp();
      chk(reg_of(2), 28'h7654321, "R8", "region-class applied on strobe");

      send(12'd4, 28'h0AAAAAA, 40);
      send(12'd4, 28'h0555555, 40);
      chk(reg_of(4), '0, "R9", "two writes still held");
      pulse_vd();
      chk(reg_of(4), 28'h0555555, "R9", "last frame-class write wins");
      send(12'd5, 28'h1111111, 40);
      send(12'd5, 28'h2222222, 40);
      pulse_scp();
      chk(reg_of(5), 28'h2222222, "R9", "last region-class write wins");
      pulse_vd();
      chk(reg_of(4), 28'h0555555, "R9", "repeat strobe without write");

      send(12'd3, 28'hFFFFFFF, 39);
      chk(reg_of(3), 28'h0000001, "R5", "39-bit frame discarded");
      send(12'd3, 28'h00C0FFE, 40);
      chk(reg_of(3), 28'h00C0FFE, "R5", "full frame after short one");

      send(12'd6, 28'h0F0F0F0, 44);
      chk(reg_of(6), 28'h0F0F0F0, "R4", "extra bits ignored");

      send(12'd8, 28'hDEAD000, 40);
      chk(reg_of(0), 28'hABCDEF1, "R10", "address above window");
      send(12'h800, 28'hBEEF000, 40);
      chk(reg_of(0), 28'hABCDEF1, "R10", "address with high bit set");

      // R3: serial clock edges with the strobe inactive
      ser_data = 1'b1;
      for (int k = 0; k < 45; k++) begin
         repeat (HOLD) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HOLD) @(negedge clk);
         ser_clk = 1'b0;
      end
      ser_data = 1'b0;
      repeat (8) @(negedge clk);
      chk(reg_of(0), 28'hABCDEF1, "R3", "edges with strobe high, slot 0");
      chk(reg_of(3), 28'h00C0FFE, "R3", "edges with strobe high, slot 3");

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule